// File: doc/BRIEF.md
# Potentiometer Volume Scaler with Curve Lookup and Safety Clip

This block turns a stream of raw potentiometer readings into a gain and applies that gain to a stream of signed audio samples. Each reading first goes through a first-order recursive smoother, so that noise picked up on the control wire cannot reach the audio. The top bits of the smoothed value select one entry of a 64-entry gain table, which sets the volume curve. Each audio sample is multiplied by the selected gain, rounded, and limited to 95% of full scale, so that the converter downstream is never driven past its range.

The gain table starts as a linear ramp after reset and can be rewritten one entry per cycle through a plain write port. Audio enters and leaves through valid/ready handshakes. A sample transfers on a clock edge where both valid and ready are high. The output holds its data while ready is low. The input deasserts ready only when both internal stages are full and the output is stalled, so no sample is ever dropped or reordered. Control readings and table writes are plain strobes with no handshake.

Top module: `pot_volume_path`

## Requirements
- R1: The smoother keeps a 15-bit state S, which is 0 after reset. On each edge with `ctl_valid` high it becomes S + x − (S >> 3), where x is the 12-bit `ctl_data`. The smoothed control value is S >> 3. Without `ctl_valid`, S holds.
- R2: The table index is bits [11:6] of the smoothed control value.
- R3: After reset, gain entry i holds 512·i. A gain is unsigned with 15 fraction bits, so 32768 means unity. On an edge with `tbl_we` high, entry `tbl_addr` takes `tbl_data`.
- R4: The scaled value is (sample·gain + 16384) >>> 15, where the sample is signed 24-bit and the shift is arithmetic with floor. Halves therefore round toward plus infinity.
- R5: Every output is clamped to the range −7969176 to +7969176, which is 95% of the largest positive 24-bit value, with the fraction dropped.
- R6: A sample uses the gain read from the table, at the current index, just before the edge that accepts it. A table write or a control reading on that same edge affects only later samples.
- R7: A sample accepted on edge N is presented on `out_valid`/`out_data` after edge N+1, provided the output is not stalled.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `in_ready` falls once both stages are full. Every accepted sample leaves once, in order.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_valid | input | 1 | Strobe for a new potentiometer reading |
| ctl_data | input | 12 | Raw potentiometer reading, unsigned |
| tbl_we | input | 1 | Gain table write enable |
| tbl_addr | input | 6 | Gain table write address |
| tbl_data | input | 16 | Gain table write data, unsigned Q1.15 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 24 | Input sample, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can take the sample |
| out_data | output | 24 | Scaled and clipped sample, two's complement |

## Verification
The smoothed control value changes on the edge that takes a reading, and the gain used by a sample is fixed on the edge that accepts it. The scaled result then appears one edge later. The bench drives every input at the falling edge and reads the results at the next falling edge after the edge where they are due. For a sample accepted on edge N, that is the falling edge after edge N+1. A reference model of the smoother state and the table is updated on the same edges as the design. The bench therefore always knows which gain a given sample must see, including when a table write lands on the accepting edge. In the stall test, the output is read on several falling edges while `out_ready` is low, to confirm it holds. `in_ready` is sampled on the falling edge before the edge at which a transfer would happen.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int CTL_W   = 12;  // potentiometer reading width
  localparam int SMOOTH_K = 3;  // smoother shift
  localparam int IDX_W   = 6;   // table index width
  localparam int GAIN_W  = 16;  // unsigned Q1.15 gain
  localparam int GAIN_FR = 15;  // fraction bits of the gain
  localparam int SMP_W   = 24;  // audio sample width
  localparam int CLIP_PCT = 95; // clip level in percent of full scale
endpackage

// File: rtl/vol_smoother.sv
module vol_smoother #(
  parameter int CW = vol_pkg::CTL_W,
  parameter int K  = vol_pkg::SMOOTH_K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [CW-1:0] rd_data,
  output logic [CW-1:0] smooth
);
  localparam int SW = CW + K;

  logic [SW-1:0] state_q;
  logic [SW:0]   sum_w;

  always_comb begin
    sum_w = {1'b0, state_q} + (SW+1)'(rd_data) - (SW+1)'(state_q >> K);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else if (rd_valid) state_q <= sum_w[SW-1:0];
  end

  assign smooth = state_q[SW-1:K];

  // R1: smoothed value never moves away from the reading that drives it
  p_toward_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && smooth < rd_data) |=> smooth >= $past(smooth));
  p_toward_input_dn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && smooth > rd_data) |=> smooth <= $past(smooth));
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(smooth));
endmodule

// File: rtl/vol_curve_table.sv
module vol_curve_table #(
  parameter int IW = vol_pkg::IDX_W,
  parameter int GW = vol_pkg::GAIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [GW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [GW-1:0] rd_gain
);
  localparam int DEPTH     = 1 << IW;
  localparam int RAMP_STEP = (1 << (GW - 1)) / DEPTH;

  logic [GW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= GW'(g * RAMP_STEP);
      else if (wr_en && (wr_addr == IW'(g))) mem_q[g] <= wr_data;
    end
  end

  assign rd_gain = mem_q[rd_idx];

  // R3: a write lands in the addressed entry
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/vol_scale_clip.sv
module vol_scale_clip #(
  parameter int DW  = vol_pkg::SMP_W,
  parameter int GW  = vol_pkg::GAIN_W,
  parameter int FR  = vol_pkg::GAIN_FR,
  parameter int PCT = vol_pkg::CLIP_PCT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] gain,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  localparam int PW = DW + GW + 1;
  localparam longint FULL_L = (longint'(1) << (DW - 1)) - 1;
  localparam longint LIM_L  = (FULL_L * PCT) / 100;
  localparam logic signed [PW-1:0] LIM_P = PW'(LIM_L);
  localparam logic signed [PW-1:0] LIM_N = -LIM_P;
  localparam logic signed [PW-1:0] HALF  = PW'(longint'(1) << (FR - 1));

  // stage 1: sample and its gain, captured together
  logic          s1_valid;
  logic [DW-1:0] s1_data;
  logic [GW-1:0] s1_gain;
  logic          adv1, adv2;

  logic signed [PW-1:0] prod_w, rnd_w, clip_w;

  assign adv2    = !m_valid || m_ready;
  assign adv1    = !s1_valid || adv2;
  assign s_ready = adv1;

  always_comb begin
    prod_w = PW'($signed(s1_data)) * $signed({1'b0, s1_gain});
    rnd_w  = (prod_w + HALF) >>> FR;
    if (rnd_w > LIM_P)      clip_w = LIM_P;
    else if (rnd_w < LIM_N) clip_w = LIM_N;
    else                    clip_w = rnd_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_gain  <= '0;
    end else if (adv1) begin
      s1_valid <= s_valid;
      if (s_valid) begin
        s1_data <= s_data;
        s1_gain <= gain;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (adv2) begin
      m_valid <= s1_valid;
      if (s1_valid) m_data <= clip_w[DW-1:0];
    end
  end

  // R8: stalled output holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  // R8: not ready only when both stages hold data
  p_ready_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> (s1_valid && m_valid));
  // R5: output never beyond the clip level
  p_clip_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ($signed(m_data) <= DW'(LIM_L) && $signed(m_data) >= -$signed(DW'(LIM_L))));
  // R6: a waiting sample keeps the gain it was accepted with
  p_gain_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !adv2) |=> $stable(s1_gain));
endmodule

// File: rtl/pot_volume_path.sv
module pot_volume_path #(
  parameter int CW = vol_pkg::CTL_W,
  parameter int K  = vol_pkg::SMOOTH_K,
  parameter int IW = vol_pkg::IDX_W,
  parameter int GW = vol_pkg::GAIN_W,
  parameter int FR = vol_pkg::GAIN_FR,
  parameter int DW = vol_pkg::SMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_valid,
  input  logic [CW-1:0] ctl_data,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_addr,
  input  logic [GW-1:0] tbl_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic [CW-1:0] smooth_w;
  logic [IW-1:0] idx_w;
  logic [GW-1:0] gain_w;

  vol_smoother #(.CW(CW), .K(K)) u_smooth (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(ctl_valid), .rd_data(ctl_data),
    .smooth(smooth_w)
  );

  assign idx_w = smooth_w[CW-1 -: IW];

  vol_curve_table #(.IW(IW), .GW(GW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_data),
    .rd_idx(idx_w), .rd_gain(gain_w)
  );

  vol_scale_clip #(.DW(DW), .GW(GW), .FR(FR), .PCT(vol_pkg::CLIP_PCT)) u_scale (
    .clk(clk), .rst_n(rst_n),
    .gain(gain_w),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(in_data),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(out_data)
  );

  // R7: an accepted sample shows up one edge later when the output is free
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (!out_valid || out_ready)) |=> ##1 out_valid);
endmodule

// File: tb/tb_pot_volume_path.sv
module tb_pot_volume_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_valid = 1'b0;
  logic [11:0] ctl_data = '0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_addr = '0;
  logic [15:0] tbl_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;

  always #10 clk = ~clk;  // 50 MHz

  pot_volume_path dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_valid(ctl_valid), .ctl_data(ctl_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  int unsigned st_m = 0;
  int unsigned tab_m [64];

  localparam longint LIM = 7969176;
  localparam int NV = 8;
  // {pot reading, sample}
  localparam logic [35:0] VEC [NV] = '{
    {12'd4095, 24'h7FFFFF}, {12'd4095, 24'h800000},
    {12'd2048, 24'h123456}, {12'd1000, 24'hF00001},
    {12'd63,   24'h000003}, {12'd3000, 24'h400000},
    {12'd4032, 24'hFFFFFF}, {12'd512,  24'h7FFFFF}
  };

  function automatic int unsigned idx_m();
    return (st_m >> 3) >> 6;
  endfunction

  function automatic logic [23:0] scale_m(input logic [23:0] s, input int unsigned g);
    longint p = longint'($signed(s)) * longint'(g) + 16384;
    longint r = p >>> 15;
    if (r > LIM) r = LIM;
    if (r < -LIM) r = -LIM;
    return r[23:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic feed_ctl(input logic [11:0] x, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ctl_valid = 1'b1; ctl_data = x;
      @(posedge clk);
      st_m = st_m + x - (st_m >> 3);
    end
    @(negedge clk);
    ctl_valid = 1'b0;
  endtask

  task automatic write_tab(input int unsigned a, input int unsigned d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 6'(a); tbl_data = 16'(d);
    @(posedge clk);
    tab_m[a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // sample accepted on next edge, result read after the following edge
  task automatic send_check(input logic [23:0] s, input string req);
    logic [23:0] exp;
    @(negedge clk);
    in_valid = 1'b1; in_data = s;
    exp = scale_m(s, tab_m[idx_m()]);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({req, " out_valid"}, 32'(out_valid), 32'd1);
    check({req, " out_data"}, 32'(out_data), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] ea, eb, hold;
    for (int i = 0; i < 64; i++) tab_m[i] = i * 512;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_valid", 32'(out_valid), 32'd0);
    check("R9 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after release", 32'(out_valid), 32'd0);

    // R3: default entry 0 is zero gain, smoother at 0
    send_check(24'h3FFFFF, "R3 default zero gain");

    // vector walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      feed_ctl(VEC[v][35:24], 120);
      send_check(VEC[v][23:0], "R2 R5 R7 vector");
    end

    // R1: unconverged smoother, a few readings only
    feed_ctl(12'd0, 3);
    send_check(24'h200000, "R1 partial smoothing");
    feed_ctl(12'd0, 120);
    feed_ctl(12'd3200, 2);
    send_check(24'h654321, "R1 rising step");

    // R3 R4: unity and half gain through written entries
    write_tab(idx_m(), 32768);
    send_check(24'h000005, "R3 unity write");
    send_check(24'h800000, "R5 negative clip unity");
    send_check(24'h7FFFFF, "R5 positive clip unity");
    write_tab(idx_m(), 16384);
    send_check(24'h000003, "R4 round half up positive");
    send_check(24'hFFFFFD, "R4 round half up negative");
    send_check(24'h000001, "R4 round small");

    // R6: table write on the accepting edge leaves that sample alone
    @(negedge clk);
    ea = scale_m(24'h100000, tab_m[idx_m()]);
    in_valid = 1'b1; in_data = 24'h100000;
    tbl_we = 1'b1; tbl_addr = 6'(idx_m()); tbl_data = 16'd40000;
    @(posedge clk);
    tab_m[idx_m()] = 40000;
    @(negedge clk);
    in_valid = 1'b0; tbl_we = 1'b0;
    @(negedge clk);
    check("R6 old gain on write edge", 32'(out_data), 32'(ea));
    send_check(24'h100000, "R6 new gain next sample");

    // R8: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    ea = scale_m(24'h012345, tab_m[idx_m()]);
    eb = scale_m(24'hFEDCBA, tab_m[idx_m()]);
    in_valid = 1'b1; in_data = 24'h012345;
    @(negedge clk);
    check("R8 ready with one stage full", 32'(in_ready), 32'd1);
    in_data = 24'hFEDCBA;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 in_ready low when full", 32'(in_ready), 32'd0);
    check("R8 first out while stalled", 32'(out_data), 32'(ea));
    hold = out_data;
    repeat (3) @(negedge clk);
    check("R8 held valid", 32'(out_valid), 32'd1);
    check("R8 held data", 32'(out_data), 32'(hold));
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 second in order", 32'(out_data), 32'(eb));
    check("R8 second valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R8 drained", 32'(out_valid), 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule